// File: doc/BRIEF.md
# Indirect Register Window with Post-Increment Alias

This block puts a bank of peripheral control registers behind four bus addresses. One address holds a directly decoded main control register. A second address holds a 16-bit pointer. Two more addresses are data aliases that reach whichever bank register the pointer selects. The plain alias leaves the pointer alone. The auto alias adds one to the pointer once each access completes. Software can load the pointer once and then walk through a run of adjacent registers with back-to-back accesses.

The bus is simple and synchronous, with address, write data, write enable, read enable and registered read data. The register contents are driven out all the time so that the peripheral logic can use them. The bank holds seven 16-bit registers at fixed subaddresses. Every other subaddress in the 16-bit pointer space is unimplemented.

Top module: `subwin_top`

## Requirements
- R1: A synchronous active-high reset clears the pointer, the main control register, all bank registers and the read data to zero.
- R2: A write to bus address 1 loads the pointer. A read of bus address 1 returns the pointer's current value.
- R3: A write to bus address 2 (plain alias) updates the bank register selected by the pointer. A read of address 2 returns that register. Neither access changes the pointer.
- R4: An access through bus address 3 (auto alias) acts like address 2, and the pointer is one higher after the clock edge that completes the access. This holds for reads and for writes.
- R5: An auto alias access with the pointer at FFFFh leaves the pointer at 0000h.
- R6: At an unimplemented subaddress, a read through either alias returns zero and a write through either alias changes no register. The auto alias still advances the pointer.
- R7: Bus address 0 holds the main control register. It is written and read directly, whatever the pointer holds, and it never touches the bank.
- R8: Read data appears on `bus_rdata` one cycle after the read enable. An auto alias read returns the register selected before the increment.
- R9: The bank subaddresses are: first control at 00h, second control at 01h, first rate at 06h, second rate at 07h, first multichannel at 08h, second multichannel at 09h, channel enable at 0Ah. `bank_q` carries them in that order, with slot k in bits [16k+15:16k].
- R10: `bus_rdata` holds its value in every cycle with no read enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Word address: 0 main, 1 pointer, 2 plain alias, 3 auto alias |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 16 | Registered read data |
| main_ctl_q | output | 16 | Main control register contents |
| bank_q | output | 112 | Bank register contents, seven 16-bit slots |

## Verification
Assertions check every cycle for the rules that hold from one edge to the next:
- the pointer steps by one after an auto alias access;
- the pointer holds when nothing addresses it;
- the bank is untouched by writes that miss it;
- unmapped alias reads return zero;
- read data holds when no read is enabled.

The scenarios cover what needs a bus history:
- a burst written through the auto alias and read back through the plain alias after reloading the pointer;
- the wrap from FFFFh to zero;
- the read-before-increment ordering;
- the subaddress-to-slot map seen at `bank_q`.

// File: rtl/subwin_pkg.sv
package subwin_pkg;
  localparam int DW     = 16;
  localparam int NSLOT  = 7;
  localparam int SLOT_W = $clog2(NSLOT);

  typedef logic [DW-1:0] word_t;

  // subaddress of each bank slot, slot order = output order
  localparam word_t SUBMAP [NSLOT] = '{
    16'h0000, 16'h0001, 16'h0006, 16'h0007, 16'h0008, 16'h0009, 16'h000A
  };

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_sel_t;

  function automatic slot_sel_t map_sub(word_t sub);
    slot_sel_t s;
    s = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (sub == SUBMAP[i]) begin
        s.hit  = 1'b1;
        s.slot = SLOT_W'(i);
      end
    end
    return s;
  endfunction

  function automatic word_t ptr_advance(word_t p);
    return p + word_t'(1);
  endfunction
endpackage

// File: rtl/subwin_decode.sv
module subwin_decode #(
  parameter int ADDR_W  = 2,
  parameter int A_MAIN  = 0,
  parameter int A_PTR   = 1,
  parameter int A_PLAIN = 2,
  parameter int A_AUTO  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  output logic              main_wr,
  output logic              ptr_wr,
  output logic              data_wr,
  output logic              data_rd,
  output logic              inc_evt
);
  logic sel_main, sel_ptr, sel_plain, sel_auto;

  always_comb begin
    sel_main  = (addr == ADDR_W'(A_MAIN));
    sel_ptr   = (addr == ADDR_W'(A_PTR));
    sel_plain = (addr == ADDR_W'(A_PLAIN));
    sel_auto  = (addr == ADDR_W'(A_AUTO));
    main_wr   = we & sel_main;
    ptr_wr    = we & sel_ptr;
    data_wr   = we & (sel_plain | sel_auto);
    data_rd   = re & (sel_plain | sel_auto);
    inc_evt   = (we | re) & sel_auto;
  end

  always_comb begin
    AST_ONE_TARGET: assert ($onehot0({main_wr, ptr_wr, data_wr})); // R7
  end
endmodule

// File: rtl/subwin_pointer.sv
module subwin_pointer
  import subwin_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ld_evt,
  input  word_t ld_val,
  input  logic  inc_evt,
  output word_t ptr
);
  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (ld_evt)  ptr <= ld_val;
    else if (inc_evt) ptr <= ptr_advance(ptr);
  end

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_evt |=> ptr == $past(ld_val)); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc_evt && !ld_evt) |=> ptr == word_t'($past(ptr) + 17'd1)); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inc_evt && !ld_evt) |=> $stable(ptr)); // R3
endmodule

// File: rtl/subwin_bank.sv
module subwin_bank
  import subwin_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_evt,
  input  word_t                     ptr,
  input  word_t                     wdata,
  output word_t                     rd_word,
  output logic                      rd_hit,
  output logic [NSLOT-1:0][DW-1:0]  regs
);
  slot_sel_t sel;
  assign sel = map_sub(ptr);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (wr_evt && sel.hit && sel.slot == SLOT_W'(g))
        regs[g] <= wdata;
    end
  end

  always_comb begin
    rd_hit  = sel.hit;
    rd_word = sel.hit ? regs[sel.slot] : '0;
  end

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !rd_hit) |=> $stable(regs)); // R6
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> $stable(regs)); // R3
endmodule

// File: rtl/subwin_top.sv
module subwin_top
  import subwin_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int A_MAIN  = 0,
  parameter int A_PTR   = 1,
  parameter int A_PLAIN = 2,
  parameter int A_AUTO  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  input  logic                    bus_we,
  input  logic                    bus_re,
  output logic [DW-1:0]           bus_rdata,
  output logic [DW-1:0]           main_ctl_q,
  output logic [NSLOT*DW-1:0]     bank_q
);
  logic  main_wr, ptr_wr, data_wr, data_rd, inc_evt;
  word_t ptr, rd_word;
  logic  rd_hit;
  logic [NSLOT-1:0][DW-1:0] regs;

  subwin_decode #(
    .ADDR_W(ADDR_W), .A_MAIN(A_MAIN), .A_PTR(A_PTR),
    .A_PLAIN(A_PLAIN), .A_AUTO(A_AUTO)
  ) u_dec (
    .addr(bus_addr), .we(bus_we), .re(bus_re),
    .main_wr(main_wr), .ptr_wr(ptr_wr), .data_wr(data_wr),
    .data_rd(data_rd), .inc_evt(inc_evt)
  );

  subwin_pointer u_ptr (
    .clk(clk), .rst(rst), .ld_evt(ptr_wr), .ld_val(bus_wdata),
    .inc_evt(inc_evt), .ptr(ptr)
  );

  subwin_bank u_bank (
    .clk(clk), .rst(rst), .wr_evt(data_wr), .ptr(ptr), .wdata(bus_wdata),
    .rd_word(rd_word), .rd_hit(rd_hit), .regs(regs)
  );

  always_ff @(posedge clk) begin
    if (rst)
      main_ctl_q <= '0;
    else if (main_wr)
      main_ctl_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_re) begin
      if (bus_addr == ADDR_W'(A_MAIN))     bus_rdata <= main_ctl_q;
      else if (bus_addr == ADDR_W'(A_PTR)) bus_rdata <= ptr;
      else if (data_rd)                    bus_rdata <= rd_word;
      else                                 bus_rdata <= '0;
    end
  end

  assign bank_q = regs;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata)); // R10
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !rd_hit) |=> bus_rdata == '0); // R6
  AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !main_wr |=> $stable(main_ctl_q)); // R7
endmodule

// File: tb/subwin_top_bench.sv
module subwin_top_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   bus_addr = '0;
  logic [15:0]  bus_wdata = '0;
  logic         bus_we = 1'b0;
  logic         bus_re = 1'b0;
  logic [15:0]  bus_rdata;
  logic [15:0]  main_ctl_q;
  logic [111:0] bank_q;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_bank [7];
  logic [15:0] exp_main;
  logic [15:0] rv;

  always #4 clk = ~clk;

  subwin_top u_subwin_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .main_ctl_q(main_ctl_q), .bank_q(bank_q)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_bank(string req);
    for (int k = 0; k < 7; k++) chk(req, bank_q[k*16 +: 16], exp_bank[k]);
  endtask

  task automatic t_reset;
    chk("R1 rdata", bus_rdata, 16'h0);
    chk("R1 main", main_ctl_q, 16'h0);
    chk_bank("R1 bank");
    rd(2'd1, rv); chk("R1 ptr", rv, 16'h0);
  endtask

  task automatic t_burst;
    logic [15:0] subs [5] = '{16'h6, 16'h7, 16'h8, 16'h9, 16'hA};
    wr(2'd1, 16'h0006);
    for (int i = 0; i < 5; i++) begin
      wr(2'd3, 16'hA100 + 16'(i));
      exp_bank[i+2] = 16'hA100 + 16'(i);
    end
    rd(2'd1, rv); chk("R4 ptr after burst", rv, 16'h000B);
    chk_bank("R9 slot map after burst");
    for (int i = 0; i < 5; i++) begin
      wr(2'd1, subs[i]);
      rd(2'd2, rv); chk("R3 plain readback", rv, 16'hA100 + 16'(i));
      rd(2'd1, rv); chk("R3 ptr unchanged", rv, subs[i]);
    end
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h5A5A); exp_bank[1] = 16'h5A5A;
    chk_bank("R9 ctl2 slot");
    rd(2'd1, rv); chk("R3 ptr after plain write", rv, 16'h0001);
  endtask

  task automatic t_auto_read;
    wr(2'd1, 16'h0007);
    rd(2'd3, rv); chk("R8 auto read pre-increment", rv, exp_bank[3]);
    rd(2'd3, rv); chk("R8 auto read next", rv, exp_bank[4]);
    rd(2'd1, rv); chk("R4 ptr after reads", rv, 16'h0009);
  endtask

  task automatic t_wrap;
    wr(2'd1, 16'hFFFF);
    rd(2'd3, rv); chk("R6 read FFFF zero", rv, 16'h0);
    rd(2'd1, rv); chk("R5 wrap to zero", rv, 16'h0000);
    wr(2'd3, 16'hC0DE); exp_bank[0] = 16'hC0DE;
    chk_bank("R9 ctl1 slot after wrap");
    rd(2'd1, rv); chk("R4 ptr after write", rv, 16'h0001);
  endtask

  task automatic t_unmapped;
    wr(2'd1, 16'h0003);
    wr(2'd2, 16'hBEEF);
    chk_bank("R6 plain write ignored");
    rd(2'd2, rv); chk("R6 plain read zero", rv, 16'h0);
    wr(2'd3, 16'hBEEF);
    chk_bank("R6 auto write ignored");
    rd(2'd1, rv); chk("R6 ptr advanced", rv, 16'h0004);
  endtask

  task automatic t_main;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h1234); exp_main = 16'h1234;
    chk("R7 main out", main_ctl_q, exp_main);
    chk_bank("R7 bank untouched");
    rd(2'd0, rv); chk("R7 main read", rv, exp_main);
    rd(2'd1, rv); chk("R7 ptr untouched", rv, 16'h0000);
  endtask

  task automatic t_hold;
    rd(2'd0, rv);
    repeat (4) @(negedge clk);
    chk("R10 rdata hold", bus_rdata, exp_main);
    bus_addr = 2'd1;
    @(negedge clk);
    chk("R10 rdata hold addr change", bus_rdata, exp_main);
  endtask

  initial begin
    for (int k = 0; k < 7; k++) exp_bank[k] = 16'h0;
    exp_main = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_burst();
    t_auto_read();
    t_wrap();
    t_unmapped();
    t_main();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule